// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a sixteen-bit record of why the device last came out of reset and which low-power states it has entered since. Single-cycle event strobes arrive from elsewhere in the chip: power-on, brown-out, external reset pin, software reset instruction, watchdog expiry, trap conflict, illegal instruction or uninitialized register access, configuration mismatch, and the sleep and idle power-save instructions. A level input says whether deep sleep is armed. Each flag has its own set and clear events. Most flags are sticky until the next power-on.

Firmware reads the register after start-up to find out what happened. It can also overwrite any implemented flag through a write strobe and data bus. A write only changes the stored value and never starts a reset. The register value is always visible on the `status` output, and every update appears one clock after the event or write that causes it.

Top module: `reset_cause_reg`

## Requirements
- R1: While `rstN` is low, `status` is 0x0003, with the power-on flag (bit 0) and the brown-out flag (bit 1) set and all other bits clear.
- R2: A `porEv` strobe makes `status` equal 0x0003 on the next clock. This overrides every other event and any software write in the same cycle.
- R3: A `borEv` strobe sets bit 1 on the next clock and changes no other bit. No hardware event clears bit 1.
- R4: Each of these strobes sets its own bit and leaves the other bits unchanged: `extEv` sets bit 7, `swResetEv` sets bit 6, `wdtEv` sets bit 4, `trapEv` sets bit 15, `badOpEv` sets bit 14 and `cfgMisEv` sets bit 9. These bits stay set until a power-on or a software write.
- R5: `sleepEv` sets the sleep flag (bit 3) and clears the idle flag (bit 2). `idleEv` sets bit 2 and clears bit 3. When both strobes arrive in the same cycle, both bits end up set.
- R6: The deep-sleep flag (bit 10) is set only when `sleepEv` is high and `deepSleepEn` is high in the same cycle. `deepSleepEn` on its own, or together with `idleEv`, leaves bit 10 unchanged.
- R7: With no events, a `swWrEn` strobe loads the implemented bits from `swWrData` on the next clock. Writing a flag to 1 changes no other bit.
- R8: Bits 13, 12, 11, 8 and 5 are unimplemented. They always read 0, so `status & 16'h3920` is always 0, even after writing ones to them.
- R9: When a hardware event and a software write act on the same bit in the same cycle, the hardware event decides the bit. Software controls the bits that no event touches.
- R10: When there is no event and no write in a cycle, `status` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset, equivalent to power-on |
| porEv | input | 1 | Power-on event strobe |
| borEv | input | 1 | Brown-out event strobe |
| extEv | input | 1 | External reset pin event strobe |
| swResetEv | input | 1 | Software reset instruction strobe |
| wdtEv | input | 1 | Watchdog time-out strobe |
| trapEv | input | 1 | Trap conflict strobe |
| badOpEv | input | 1 | Illegal instruction or uninitialized register access strobe |
| cfgMisEv | input | 1 | Configuration mismatch strobe |
| sleepEv | input | 1 | Sleep power-save instruction strobe |
| idleEv | input | 1 | Idle power-save instruction strobe |
| deepSleepEn | input | 1 | Deep-sleep armed level |
| swWrEn | input | 1 | Software write strobe |
| swWrData | input | 16 | Software write data |
| status | output | 16 | Current register value |

## Verification
The bench applies every single event, and every event combined with a software write, from several starting patterns, including all ones and both alternating patterns. A long pseudo-random run then mixes events, the deep-sleep level and writes. Four corner cases get particular attention:
- If power-on did not take priority, a same-cycle write or watchdog flag would survive into the power-on result.
- If the write took priority over hardware, a write of zero in the same cycle as an external reset would lose the external flag.
- If the sleep and idle clears were wrong, a flag would remain set after its counterpart instruction.
- If the unimplemented bits were stored, writing all ones would make them read back as 1.

// File: rtl/rcause_pkg.sv
package rcause_pkg;
  localparam int REG_W = 16;

  localparam int POS_PWR   = 0;
  localparam int POS_BRN   = 1;
  localparam int POS_IDL   = 2;
  localparam int POS_SLP   = 3;
  localparam int POS_WDT   = 4;
  localparam int POS_SWR   = 6;
  localparam int POS_EXT   = 7;
  localparam int POS_CFG   = 9;
  localparam int POS_DSLP  = 10;
  localparam int POS_BADOP = 14;
  localparam int POS_TRAP  = 15;

  localparam logic [REG_W-1:0] ONE = REG_W'(1);

  localparam logic [REG_W-1:0] IMPL_MASK =
      (ONE << POS_PWR) | (ONE << POS_BRN) | (ONE << POS_IDL) | (ONE << POS_SLP) |
      (ONE << POS_WDT) | (ONE << POS_SWR) | (ONE << POS_EXT) | (ONE << POS_CFG) |
      (ONE << POS_DSLP) | (ONE << POS_BADOP) | (ONE << POS_TRAP);

  localparam logic [REG_W-1:0] PWRON_VAL = (ONE << POS_PWR) | (ONE << POS_BRN);

  typedef struct packed {
    logic             porLoad;
    logic             swLoad;
    logic [REG_W-1:0] setMask;
    logic [REG_W-1:0] clrMask;
  } rcause_ctl_t;
endpackage

// File: rtl/rcause_ctrl.sv
module rcause_ctrl
  import rcause_pkg::*;
(
  input  logic        porEv,
  input  logic        borEv,
  input  logic        extEv,
  input  logic        swResetEv,
  input  logic        wdtEv,
  input  logic        trapEv,
  input  logic        badOpEv,
  input  logic        cfgMisEv,
  input  logic        sleepEv,
  input  logic        idleEv,
  input  logic        deepSleepEn,
  input  logic        swWrEn,
  output rcause_ctl_t ctl
);
  logic [REG_W-1:0] setM;
  logic [REG_W-1:0] clrM;

  always_comb begin
    setM = '0;
    setM[POS_BRN]   = borEv;
    setM[POS_EXT]   = extEv;
    setM[POS_SWR]   = swResetEv;
    setM[POS_WDT]   = wdtEv;
    setM[POS_TRAP]  = trapEv;
    setM[POS_BADOP] = badOpEv;
    setM[POS_CFG]   = cfgMisEv;
    setM[POS_SLP]   = sleepEv;
    setM[POS_IDL]   = idleEv;
    setM[POS_DSLP]  = sleepEv & deepSleepEn;
  end

  // A power-save instruction clears the flag of the other power-save state.
  always_comb begin
    clrM = '0;
    clrM[POS_IDL] = sleepEv;
    clrM[POS_SLP] = idleEv;
  end

  always_comb begin
    ctl.porLoad = porEv;
    ctl.swLoad  = swWrEn;
    ctl.setMask = setM;
    ctl.clrMask = clrM;
  end
endmodule

// File: rtl/rcause_dp.sv
module rcause_dp
  import rcause_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  rcause_ctl_t      ctl,
  input  logic [REG_W-1:0] swWrData,
  output logic [REG_W-1:0] regQ
);
  // Priority per bit: power-on, then set, then clear, then software write.
  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                regQ[i] <= PWRON_VAL[i];
        else if (ctl.porLoad)     regQ[i] <= PWRON_VAL[i];
        else if (ctl.setMask[i])  regQ[i] <= 1'b1;
        else if (ctl.clrMask[i])  regQ[i] <= 1'b0;
        else if (ctl.swLoad)      regQ[i] <= swWrData[i];
      end
    end else begin : g_none
      assign regQ[i] = 1'b0;
    end
  end

  logic unusedBits;
  assign unusedBits = ^((ctl.setMask | ctl.clrMask | swWrData) & ~IMPL_MASK);
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
  import rcause_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             porEv,
  input  logic             borEv,
  input  logic             extEv,
  input  logic             swResetEv,
  input  logic             wdtEv,
  input  logic             trapEv,
  input  logic             badOpEv,
  input  logic             cfgMisEv,
  input  logic             sleepEv,
  input  logic             idleEv,
  input  logic             deepSleepEn,
  input  logic             swWrEn,
  input  logic [REG_W-1:0] swWrData,
  output logic [REG_W-1:0] status
);
  rcause_ctl_t ctl;

  rcause_ctrl ctrl_i (
    .porEv(porEv), .borEv(borEv), .extEv(extEv), .swResetEv(swResetEv),
    .wdtEv(wdtEv), .trapEv(trapEv), .badOpEv(badOpEv), .cfgMisEv(cfgMisEv),
    .sleepEv(sleepEv), .idleEv(idleEv), .deepSleepEn(deepSleepEn),
    .swWrEn(swWrEn), .ctl(ctl)
  );

  rcause_dp dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .swWrData(swWrData), .regQ(status)
  );
endmodule

// File: rtl/rcause_chk.sv
module rcause_chk
  import rcause_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             porEv,
  input logic             borEv,
  input logic             extEv,
  input logic             swResetEv,
  input logic             wdtEv,
  input logic             trapEv,
  input logic             badOpEv,
  input logic             cfgMisEv,
  input logic             sleepEv,
  input logic             idleEv,
  input logic             deepSleepEn,
  input logic             swWrEn,
  input logic [REG_W-1:0] swWrData,
  input logic [REG_W-1:0] status
);
  logic anyEv;
  assign anyEv = porEv | borEv | extEv | swResetEv | wdtEv | trapEv |
                 badOpEv | cfgMisEv | sleepEv | idleEv;

  a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    (status & ~IMPL_MASK) == '0);

  a_r2_pwron_value: assert property (@(posedge clk) disable iff (!rstN)
    porEv |=> status == PWRON_VAL);

  a_r3_brownout_set: assert property (@(posedge clk) disable iff (!rstN)
    (borEv && !porEv) |=> status[POS_BRN]);

  a_r5_sleep_swap: assert property (@(posedge clk) disable iff (!rstN)
    (sleepEv && !idleEv && !porEv) |=> (status[POS_SLP] && !status[POS_IDL]));

  a_r6_deep_sleep: assert property (@(posedge clk) disable iff (!rstN)
    (sleepEv && deepSleepEn && !porEv) |=> status[POS_DSLP]);

  a_r7_sw_load: assert property (@(posedge clk) disable iff (!rstN)
    (swWrEn && !anyEv) |=> status == ($past(swWrData) & IMPL_MASK));

  a_r9_hw_beats_write: assert property (@(posedge clk) disable iff (!rstN)
    (swWrEn && extEv && !porEv) |=> status[POS_EXT]);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!anyEv && !swWrEn) |=> $stable(status));
endmodule

bind reset_cause_reg rcause_chk chk_i (
  .clk(clk), .rstN(rstN), .porEv(porEv), .borEv(borEv), .extEv(extEv),
  .swResetEv(swResetEv), .wdtEv(wdtEv), .trapEv(trapEv), .badOpEv(badOpEv),
  .cfgMisEv(cfgMisEv), .sleepEv(sleepEv), .idleEv(idleEv),
  .deepSleepEn(deepSleepEn), .swWrEn(swWrEn), .swWrData(swWrData),
  .status(status)
);

// File: tb/reset_cause_reg_tb_top.sv
module reset_cause_reg_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [10:0] ev = '0;  // 0 por,1 bor,2 ext,3 swr,4 wdt,5 trap,6 badop,7 cfg,8 sleep,9 idle,10 dsen
  logic        wr = 1'b0;
  logic [15:0] wd = '0;
  logic [15:0] status;
  int          nChecks = 0;
  int          nFails = 0;
  int          cycles = 0;

  always #10 clk = ~clk;

  reset_cause_reg dut_i (
    .clk(clk), .rstN(rstN), .porEv(ev[0]), .borEv(ev[1]), .extEv(ev[2]),
    .swResetEv(ev[3]), .wdtEv(ev[4]), .trapEv(ev[5]), .badOpEv(ev[6]),
    .cfgMisEv(ev[7]), .sleepEv(ev[8]), .idleEv(ev[9]), .deepSleepEn(ev[10]),
    .swWrEn(wr), .swWrData(wd), .status(status)
  );

  localparam logic [15:0] MASK = 16'hC6DF;

  function automatic logic [15:0] model(logic [15:0] cur, logic [10:0] e,
                                        logic w, logic [15:0] d);
    logic [15:0] n;
    n = w ? (d & MASK) : cur;
    if (e[8]) n[2] = 1'b0;
    if (e[9]) n[3] = 1'b0;
    if (e[1]) n[1] = 1'b1;
    if (e[2]) n[7] = 1'b1;
    if (e[3]) n[6] = 1'b1;
    if (e[4]) n[4] = 1'b1;
    if (e[5]) n[15] = 1'b1;
    if (e[6]) n[14] = 1'b1;
    if (e[7]) n[9] = 1'b1;
    if (e[8]) n[3] = 1'b1;
    if (e[9]) n[2] = 1'b1;
    if (e[8] && e[10]) n[10] = 1'b1;
    if (e[0]) n = 16'h0003;
    return n;
  endfunction

  function automatic string tagOf(int i);
    case (i)
      0: return "R2";
      1: return "R3";
      8, 9: return "R5";
      10: return "R6";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] exp);
    nChecks++;
    if (status !== exp) begin
      nFails++;
      $display("FAIL %s: status=%h expected=%h", tag, status, exp);
    end
  endtask

  task automatic cyc(logic [10:0] e, logic w, logic [15:0] d, string tag);
    logic [15:0] exp;
    exp = model(status, e, w, d);
    ev = e; wr = w; wd = d;
    @(posedge clk); #1;
    ev = '0; wr = 1'b0; wd = '0;
    check(tag, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFails++;
      $display("FAIL watchdog: cycles=%0d expected<=150000", cycles);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [15:0] starts [4];
    starts[0] = 16'h0000; starts[1] = 16'hFFFF;
    starts[2] = 16'hAAAA; starts[3] = 16'h5555;

    #35;
    check("R1", 16'h0003);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1", 16'h0003);

    cyc('0, 1'b0, '0, "R10");
    cyc('0, 1'b1, 16'hFFFF, "R8");
    check("R8", 16'hC6DF);
    cyc('0, 1'b1, 16'h0000, "R7");
    cyc('0, 1'b1, 16'h0080, "R7");
    cyc(11'h004, 1'b1, 16'h0000, "R9");
    check("R9", 16'h0080);
    cyc(11'h010, 1'b1, 16'hFFFF, "R2");
    cyc(11'h001, 1'b1, 16'hFFFF, "R2");
    check("R2", 16'h0003);
    cyc(11'h300, 1'b0, '0, "R5");
    check("R5", 16'h000F);
    cyc(11'h400, 1'b0, '0, "R6");
    check("R6", 16'h000F);
    cyc(11'h600, 1'b0, '0, "R6");
    cyc(11'h500, 1'b0, '0, "R6");
    check("R6", 16'h040B);

    // Single events and events with writes from several start patterns.
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 11; i++) begin
        cyc('0, 1'b1, starts[s], "R7");
        cyc(11'(1) << i, 1'b0, '0, tagOf(i));
        cyc('0, 1'b0, '0, "R10");
        cyc(11'(1) << i, 1'b1, ~starts[s], "R9");
        cyc((11'(1) << i) | 11'h400, 1'b0, '0, tagOf(i));
      end
    end

    // Pseudo-random mixed sweep.
    lfsr = 16'hACE1;
    for (int k = 0; k < 4000; k++) begin
      logic [10:0] e;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      e = 11'(1) << (lfsr[3:0] % 11);
      if (lfsr[6:4] != 3'd0) e = '0;
      if (e == 11'h001 && lfsr[9:7] != 3'd0) e = '0;
      e[10] = lfsr[11];
      cyc(e, lfsr[12] & lfsr[13], {lfsr[7:0], lfsr[15:8]}, "R9");
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule